// File: doc/BRIEF.md
# SPI Master Command-Word Transmit Queue

This block is the transmit side of an SPI master that is fed whole command words rather than bare data bytes. Each 32-bit word pushed into it carries one 8-bit frame plus the control that goes with that frame:
- which chip-select lines are driven during it
- which of two clock rates applies
- whether the selection is held into the following word
- whether the word ends a sequence

Words wait in a four-entry FIFO. A serialising engine takes them one at a time. It drives SCK and MOSI in SPI mode 0 and moves the active-low chip-select outputs by itself, so software or a DMA engine never toggles a select pin.

A fill request is high whenever the FIFO has room and the request is enabled. A DMA channel can therefore pace its writes on it, one word per request. When the word that closes a sequence has fully shifted out and its select has been released, a sticky end-of-sequence flag is set. Software clears it by writing a one. A word pushed into a full FIFO is discarded and sets a sticky overflow flag, which is cleared the same way.

Command word layout, with bits 31 to 15 ignored:

| Bits | Meaning |
|------|---------|
| 7:0 | data, sent MSB first |
| 11:8 | chip-select mask, bit n selects line n |
| 12 | rate select |
| 13 | hold select |
| 14 | end of sequence |

Top module: `spi_cmd_txq`

## Requirements
- R1: After reset, SCK is low, every `cs_n` line is high, `eoq_flag` and `ovf_flag` are 0, and `fill_req` equals `req_en`.
- R2: Each word's bits [7:0] are sent MSB first on `mosi`. Each bit is stable while SCK is high, sampled on the rising SCK edge, and changed only while SCK is low (mode 0). SCK is low between frames.
- R3: During a frame, `cs_n[n]` is low exactly for the lines n whose bit 8+n of the word is 1. All other lines stay high.
- R4: If bit 13 (hold) of a word is 1 and bit 14 is 0, the selected lines stay low after that frame and are still low when the next word begins.
- R5: If bit 13 of a word is 0, all `cs_n` lines return high after that frame.
- R6: A word with bit 14 (end) set releases all `cs_n` lines after its frame, even if bit 13 is set. In the same cycle it sets `eoq_flag`. A one-cycle pulse on `eoq_clr` clears the flag.
- R7: Bit 12 selects the SCK half period. 0 selects `div_a` clock cycles and 1 selects `div_b` clock cycles; a divider value of 0 acts as 1.
- R8: When `cs_n` falls from all-high, SCK first rises exactly one half period later. After the last falling SCK edge of a frame, a line that is released stays low for exactly one half period.
- R9: `fill_req` is 1 exactly when `req_en` is 1 and the 4-entry FIFO is not full.
- R10: A word pushed while the FIFO is full is dropped and is never sent. `ovf_flag` is set on the next cycle, and a one-cycle pulse on `ovf_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| push_valid | input | 1 | write strobe for `push_word` |
| push_word | input | 32 | command word |
| req_en | input | 1 | enables the fill request |
| div_a | input | 8 | SCK half period in clocks, rate 0 |
| div_b | input | 8 | SCK half period in clocks, rate 1 |
| eoq_clr | input | 1 | write-one clear of `eoq_flag` |
| ovf_clr | input | 1 | write-one clear of `ovf_flag` |
| sck | output | 1 | serial clock |
| mosi | output | 1 | serial data out |
| cs_n | output | 4 | active-low chip selects |
| fill_req | output | 1 | FIFO has room, request enabled |
| eoq_flag | output | 1 | sticky end-of-sequence status |
| ovf_flag | output | 1 | sticky overflow status |

## Verification
The assertions assume that `div_a` and `div_b` stay constant while a frame is in flight, and that the pushes in any one held-select sequence share one chip-select mask. The bench changes the dividers only while the engine is idle, and it gives every word of a held sequence the same mask. The overflow property reads "fill request low while enabled" as "FIFO full", so the bench holds `req_en` high whenever it pushes.

// File: rtl/spi_cmd_txq_pkg.sv
package spi_cmd_txq_pkg;
    localparam int TXQ_FRAME_W = 8;
    localparam int TXQ_NCS     = 4;
    localparam int TXQ_CS_LSB  = 8;
    localparam int TXQ_SEL_BIT = 12;
    localparam int TXQ_CONT_BIT = 13;
    localparam int TXQ_EOQ_BIT = 14;
    localparam int TXQ_CMD_W   = TXQ_EOQ_BIT + 1;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SETUP = 2'd1,
        ENG_SHIFT = 2'd2,
        ENG_HOLD  = 2'd3
    } eng_state_e;
endpackage

// File: rtl/spi_txq_fifo.sv
module spi_txq_fifo #(
    parameter int WIDTH = 15,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic             drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  do_wr, do_rd;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign rdata = s_q.mem[s_q.rp];
    assign drop  = wr && full;

    always_comb begin
        s_d   = s_q;
        do_wr = wr && !full;
        do_rd = rd && !empty;
        if (do_wr) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (do_rd) begin
            s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/spi_txq_engine.sv
module spi_txq_engine
    import spi_cmd_txq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 avail,
    input  logic [TXQ_CMD_W-1:0] cmd,
    input  logic [DIV_W-1:0]     div_a,
    input  logic [DIV_W-1:0]     div_b,
    output logic                 pop,
    output logic                 eoq_evt,
    output logic                 sck,
    output logic                 mosi,
    output logic [TXQ_NCS-1:0]   cs_n
);
    localparam int BIT_W = $clog2(TXQ_FRAME_W);

    typedef struct packed {
        eng_state_e             st;
        logic [DIV_W-1:0]       cnt;
        logic [DIV_W-1:0]       half;
        logic [BIT_W-1:0]       bitn;
        logic [TXQ_FRAME_W-1:0] sh;
        logic                   sck;
        logic [TXQ_NCS-1:0]     cs_n;
        logic                   cont;
        logic                   eoq;
    } eng_t;

    eng_t             e_d, e_q;
    logic [DIV_W-1:0] pick;

    assign sck  = e_q.sck;
    assign mosi = e_q.sh[TXQ_FRAME_W-1];
    assign cs_n = e_q.cs_n;

    always_comb begin
        e_d     = e_q;
        pop     = 1'b0;
        eoq_evt = 1'b0;
        pick    = cmd[TXQ_SEL_BIT] ? div_b : div_a;
        if (pick == '0) pick = DIV_W'(1);
        case (e_q.st)
            ENG_IDLE: begin
                if (avail) begin
                    pop       = 1'b1;
                    e_d.sh    = cmd[TXQ_FRAME_W-1:0];
                    e_d.cs_n  = ~cmd[TXQ_CS_LSB +: TXQ_NCS];
                    e_d.cont  = cmd[TXQ_CONT_BIT];
                    e_d.eoq   = cmd[TXQ_EOQ_BIT];
                    e_d.half  = pick;
                    e_d.cnt   = pick - 1'b1;
                    e_d.st    = ENG_SETUP;
                end
            end
            ENG_SETUP: begin
                if (e_q.cnt == '0) begin
                    e_d.sck  = 1'b1;
                    e_d.bitn = '0;
                    e_d.cnt  = e_q.half - 1'b1;
                    e_d.st   = ENG_SHIFT;
                end else begin
                    e_d.cnt = e_q.cnt - 1'b1;
                end
            end
            ENG_SHIFT: begin
                if (e_q.cnt != '0) begin
                    e_d.cnt = e_q.cnt - 1'b1;
                end else begin
                    e_d.cnt = e_q.half - 1'b1;
                    e_d.sck = ~e_q.sck;
                    if (e_q.sck) begin
                        if (e_q.bitn == BIT_W'(TXQ_FRAME_W - 1)) begin
                            e_d.st = ENG_HOLD;
                        end else begin
                            e_d.bitn = e_q.bitn + 1'b1;
                            e_d.sh   = {e_q.sh[TXQ_FRAME_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ENG_HOLD: begin
                if (e_q.cnt != '0) begin
                    e_d.cnt = e_q.cnt - 1'b1;
                end else begin
                    if (e_q.eoq || !e_q.cont) e_d.cs_n = '1;
                    eoq_evt = e_q.eoq;
                    e_d.st  = ENG_IDLE;
                end
            end
            default: e_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.st   <= ENG_IDLE;
            e_q.cs_n <= '1;
        end else begin
            e_q <= e_d;
        end
    end
endmodule

// File: rtl/spi_cmd_txq.sv
module spi_cmd_txq
    import spi_cmd_txq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic [31:0]        push_word,
    input  logic               req_en,
    input  logic [DIV_W-1:0]   div_a,
    input  logic [DIV_W-1:0]   div_b,
    input  logic               eoq_clr,
    input  logic               ovf_clr,
    output logic               sck,
    output logic               mosi,
    output logic [TXQ_NCS-1:0] cs_n,
    output logic               fill_req,
    output logic               eoq_flag,
    output logic               ovf_flag
);
    typedef struct packed {
        logic eoq;
        logic ovf;
    } flag_t;

    flag_t                f_d, f_q;
    logic [TXQ_CMD_W-1:0] head;
    logic                 empty, full, drop, pop, eoq_evt;
    logic                 unused_hi;

    assign unused_hi = ^push_word[31:TXQ_CMD_W];

    spi_txq_fifo #(.WIDTH(TXQ_CMD_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (push_valid),
        .wdata (push_word[TXQ_CMD_W-1:0]),
        .rd    (pop),
        .rdata (head),
        .empty (empty),
        .full  (full),
        .drop  (drop)
    );

    spi_txq_engine #(.DIV_W(DIV_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .avail   (!empty),
        .cmd     (head),
        .div_a   (div_a),
        .div_b   (div_b),
        .pop     (pop),
        .eoq_evt (eoq_evt),
        .sck     (sck),
        .mosi    (mosi),
        .cs_n    (cs_n)
    );

    always_comb begin
        f_d = f_q;
        if (eoq_clr) f_d.eoq = 1'b0;
        if (ovf_clr) f_d.ovf = 1'b0;
        if (eoq_evt) f_d.eoq = 1'b1;
        if (drop)    f_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign fill_req = req_en && !full;
    assign eoq_flag = f_q.eoq;
    assign ovf_flag = f_q.ovf;
endmodule

// File: rtl/spi_cmd_txq_chk.sv
module spi_cmd_txq_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sck,
    input logic           mosi,
    input logic [NCS-1:0] cs_n,
    input logic           push_valid,
    input logic           req_en,
    input logic           fill_req,
    input logic           eoq_flag,
    input logic           ovf_flag
);
    // R3
    sck_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> (cs_n != '1));

    // R2
    mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R8
    cs_moves_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != $past(cs_n)) |-> (!sck && !$past(sck)));

    // R6
    eoq_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoq_flag) |-> (cs_n == '1));

    // R10
    overflow_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && req_en && !fill_req) |=> ovf_flag);
endmodule

bind spi_cmd_txq spi_cmd_txq_chk #(.NCS(spi_cmd_txq_pkg::TXQ_NCS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (sck),
    .mosi       (mosi),
    .cs_n       (cs_n),
    .push_valid (push_valid),
    .req_en     (req_en),
    .fill_req   (fill_req),
    .eoq_flag   (eoq_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/spi_cmd_txq_test.sv
`timescale 1ns/1ps
module spi_cmd_txq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [31:0] push_word = '0;
    logic        req_en = 1'b0;
    logic [7:0]  div_a = 8'd2;
    logic [7:0]  div_b = 8'd3;
    logic        eoq_clr = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        sck, mosi, fill_req, eoq_flag, ovf_flag;
    logic [3:0]  cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] d;
        logic [3:0] m;
        int         half;
        bit         cont;
        bit         eoq;
    } exp_t;
    exp_t exp_q[$];

    spi_cmd_txq uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_word(push_word),
        .req_en(req_en), .div_a(div_a), .div_b(div_b), .eoq_clr(eoq_clr),
        .ovf_clr(ovf_clr), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .fill_req(fill_req), .eoq_flag(eoq_flag), .ovf_flag(ovf_flag)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [3:0] m, input bit sel,
                        input bit cont, input bit eoq, input bit accept);
        exp_t e;
        int   h;
        h = sel ? int'(div_b) : int'(div_a);
        if (h == 0) h = 1;
        e = '{d: d, m: m, half: h, cont: cont, eoq: eoq};
        if (accept) exp_q.push_back(e);
        @(negedge clk);
        push_word  = {17'h1ABCD, eoq, cont, sel, m, d};
        push_valid = 1'b1;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (40) @(negedge clk);
    endtask

    task automatic clear_eoq();
        @(negedge clk); eoq_clr = 1'b1;
        @(negedge clk); eoq_clr = 1'b0;
        chk(eoq_flag == 1'b0, "R6 eoq clear", eoq_flag, 0);
    endtask

    // scoreboard monitor
    initial begin
        logic       p_sck;
        logic [3:0] p_cs, cs_cap;
        logic [7:0] bits;
        int nbit, hi_cnt, setup_cnt, k;
        bit in_setup, meas_hi, in_hold;
        exp_t cur;
        nbit = 0; in_setup = 0; meas_hi = 0; in_hold = 0;
        hi_cnt = 0; setup_cnt = 0; k = 0; bits = '0; cs_cap = '1;
        @(posedge rst_n);
        @(negedge clk);
        p_sck = sck; p_cs = cs_n;
        forever begin
            @(negedge clk);
            if (p_cs == 4'hF && cs_n != 4'hF) begin
                in_setup = 1; setup_cnt = 0;
            end
            if (in_setup && !sck) setup_cnt++;
            if (sck && !p_sck) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected frame", 1, 0);
                end else if (in_setup) begin
                    // R8 setup
                    chk(setup_cnt == exp_q[0].half, "R8 setup", setup_cnt, exp_q[0].half);
                end
                in_setup = 0;
                bits = {bits[6:0], mosi};
                nbit++;
                if (nbit == 1) begin
                    cs_cap = cs_n; meas_hi = 1; hi_cnt = 0;
                end
            end
            if (meas_hi) begin
                if (sck) hi_cnt++;
                else meas_hi = 0;
            end
            if (!sck && p_sck && nbit == 8 && exp_q.size() != 0) begin
                cur = exp_q.pop_front();
                chk(bits == cur.d, "R2 data", bits, cur.d);
                chk(cs_cap == ~cur.m, "R3 select", cs_cap, ~cur.m);
                chk(hi_cnt == cur.half, "R7 half", hi_cnt, cur.half);
                nbit = 0; in_hold = 1; k = 0;
            end
            if (in_hold) begin
                if (k == cur.half - 1)
                    chk(cs_n == ~cur.m, "R8 hold", cs_n, ~cur.m);
                if (k == cur.half) begin
                    if (cur.eoq) begin
                        chk(cs_n == 4'hF, "R6 release", cs_n, 4'hF);
                        chk(eoq_flag == 1'b1, "R6 flag", eoq_flag, 1);
                    end else if (cur.cont) begin
                        chk(cs_n == ~cur.m, "R4 held", cs_n, ~cur.m);
                    end else begin
                        chk(cs_n == 4'hF, "R5 release", cs_n, 4'hF);
                    end
                    in_hold = 0;
                end
                k++;
            end
            p_sck = sck; p_cs = cs_n;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        req_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(cs_n == 4'hF, "R1 cs_n", cs_n, 4'hF);
        chk(eoq_flag == 1'b0 && ovf_flag == 1'b0, "R1 flags", {eoq_flag, ovf_flag}, 0);
        chk(fill_req == 1'b1, "R1 R9 fill_req", fill_req, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // single frame with end flag, rate a
        push(8'hA5, 4'b0001, 0, 0, 1, 1);
        drain();
        clear_eoq();

        // held sequence on rate b, end on last
        push(8'h3C, 4'b0100, 1, 1, 0, 1);
        push(8'h81, 4'b0100, 1, 1, 0, 1);
        push(8'hFF, 4'b0100, 1, 1, 1, 1);
        drain();
        chk(eoq_flag == 1'b1, "R6 flag sticky", eoq_flag, 1);
        clear_eoq();

        // separate frames, divider 0 acts as 1
        div_a = 8'd0;
        push(8'h00, 4'b0010, 0, 0, 0, 1);
        push(8'h5A, 4'b0011, 0, 0, 0, 1);
        drain();
        chk(eoq_flag == 1'b0, "R5 no eoq", eoq_flag, 0);

        // R9 request disabled while not full
        req_en = 1'b0;
        @(negedge clk);
        chk(fill_req == 1'b0, "R9 disabled", fill_req, 0);
        req_en = 1'b1;
        @(negedge clk);
        chk(fill_req == 1'b1, "R9 enabled", fill_req, 1);

        // overflow burst on slow rate
        div_a = 8'd6;
        push(8'h11, 4'b1000, 0, 1, 0, 1);
        push(8'h22, 4'b1000, 0, 1, 0, 1);
        push(8'h33, 4'b1000, 0, 1, 0, 1);
        push(8'h44, 4'b1000, 0, 1, 0, 1);
        chk(ovf_flag == 1'b0, "R10 no overflow yet", ovf_flag, 0);
        push(8'h55, 4'b1000, 0, 0, 1, 1);
        chk(fill_req == 1'b0, "R9 full", fill_req, 0);
        push(8'hEE, 4'b1000, 0, 0, 1, 0);
        chk(ovf_flag == 1'b1, "R10 overflow", ovf_flag, 1);
        drain();
        chk(exp_q.size() == 0, "R10 dropped word not sent", exp_q.size(), 0);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk(ovf_flag == 1'b0, "R10 clear", ovf_flag, 0);
        clear_eoq();
        chk(cs_n == 4'hF && sck == 1'b0, "R2 idle lines", {cs_n, sck}, 5'h1E);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule